// File: doc/BRIEF.md
# Memory Operation Ordering Queue with Barriers

This block decides, every cycle, which in-flight memory operations may be sent to execution. It keeps one table of load entries and one table of store entries, each of configurable depth. An upstream dispatcher allocates an operation by presenting three flags and an age tag. The flags say whether the operation may read memory, whether it may write memory and whether it has side effects. The age is a wrapping sequence number in program order. An operation that may read takes a load entry. One that may write takes a store entry. One that does both takes one of each.

When side effects are combined with a read flag, the entry is a load barrier. Side effects with a write flag give a store barrier, and side effects with both flags give a full barrier that holds one entry in each table. A barrier is sent to execution only when it is the oldest entry still present in its table or tables. Younger operations of its kind are held until it has been sent, but the load barrier does not empty the load table. At most one load-side grant and one store-side grant are issued per cycle, and each goes to the oldest eligible entry. A static no-alias input lets loads overtake older stores. An entry stays in its table after its grant and is freed by a completion input that carries its index.

Top module: `lsq_order_top`

## Requirements
- R1: After reset both tables are empty. No grant is raised, neither full flag is raised, and both allocation index outputs read 0.
- R2: An accepted allocation with only the read flag takes one load entry. One with only the write flag takes one store entry, and one with both flags takes one of each. The entry taken is always the lowest-numbered free slot, which `alloc_lq_idx` and `alloc_sq_idx` show before the allocation.
- R3: `lq_full` and `sq_full` are high exactly when every slot of that table is occupied. An allocation that needs a full table is dropped as a whole and leaves no entry in either table.
- R4: A store that is not a barrier is granted only when every older load entry and every older store entry has already been granted.
- R5: With `noalias_en` low, a non-barrier load is granted only when every older store entry has been granted. With `noalias_en` high, older stores alone do not hold it back.
- R6: A non-barrier load is not granted while there is an ungranted store entry that is younger than some ungranted load entry and older than the load itself.
- R7: A load barrier (read and side-effect flags) is granted only when no older entry remains in the load table. No younger load is granted before the barrier has been granted. The same rule holds for a store barrier in the store table.
- R8: A full barrier (all three flags) is granted on both ports in the same cycle, and only when it is the oldest remaining entry in both tables.
- R9: Each port grants at most one entry per cycle, to the oldest eligible entry that has not yet been granted. An entry is granted only once.
- R10: A completion on an entry that has been granted frees that slot for the next cycle. A completion on an entry that is empty, not yet granted or out of range is ignored.
- R11: An allocation with neither the read nor the write flag, with or without the side-effect flag, allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| noalias_en | input | 1 | Static mode: loads may overtake older stores |
| alloc_vld | input | 1 | Allocation request |
| alloc_may_ld | input | 1 | Operation may read memory |
| alloc_may_st | input | 1 | Operation may write memory |
| alloc_side_fx | input | 1 | Operation has side effects |
| alloc_age | input | AGE_W | Wrapping program-order age |
| alloc_lq_idx | output | LQ_IW | Load slot the next allocation takes |
| alloc_sq_idx | output | SQ_IW | Store slot the next allocation takes |
| lq_full | output | 1 | Load table full |
| sq_full | output | 1 | Store table full |
| ld_gnt_vld | output | 1 | Load-side grant this cycle |
| ld_gnt_idx | output | LQ_IW | Granted load slot |
| st_gnt_vld | output | 1 | Store-side grant this cycle |
| st_gnt_idx | output | SQ_IW | Granted store slot |
| ld_done_vld | input | 1 | Load-side completion |
| ld_done_idx | input | LQ_IW | Completed load slot |
| st_done_vld | input | 1 | Store-side completion |
| st_done_idx | input | SQ_IW | Completed store slot |

## Verification
The bench builds the block with four load slots, three store slots and a five-bit age. At these sizes both tables fill often, so allocation drops while full are exercised. The age counter wraps many times during a run, which tests the wrapped-age comparison. With three store slots, the two-bit store index can name a slot that does not exist, so out-of-range completions are covered. Separate runs with `noalias_en` low and high are checked against a behavioural model that holds entries by absolute sequence number.

// File: rtl/lsq_order_pkg.sv
package lsq_order_pkg;

    typedef enum logic [2:0] {
        OPK_NONE  = 3'd0,
        OPK_LOAD  = 3'd1,
        OPK_STORE = 3'd2,
        OPK_RMW   = 3'd3,
        OPK_LBAR  = 3'd4,
        OPK_SBAR  = 3'd5,
        OPK_FBAR  = 3'd6
    } op_kind_e;

    // Maps the three allocation flags to an operation kind.
    function automatic op_kind_e classify(input logic rd, input logic wr, input logic fx);
        op_kind_e k;
        unique case ({rd, wr, fx})
            3'b100:  k = OPK_LOAD;
            3'b010:  k = OPK_STORE;
            3'b110:  k = OPK_RMW;
            3'b101:  k = OPK_LBAR;
            3'b011:  k = OPK_SBAR;
            3'b111:  k = OPK_FBAR;
            default: k = OPK_NONE;
        endcase
        return k;
    endfunction

    function automatic logic kind_uses_lq(input op_kind_e k);
        return (k == OPK_LOAD) || (k == OPK_RMW) || (k == OPK_LBAR) || (k == OPK_FBAR);
    endfunction

    function automatic logic kind_uses_sq(input op_kind_e k);
        return (k == OPK_STORE) || (k == OPK_RMW) || (k == OPK_SBAR) || (k == OPK_FBAR);
    endfunction

    function automatic logic kind_is_bar(input op_kind_e k);
        return (k == OPK_LBAR) || (k == OPK_SBAR) || (k == OPK_FBAR);
    endfunction

    // True when age a precedes age b in a wrapping space of w bits.
    function automatic logic age_before(input logic [31:0] a, input logic [31:0] b,
                                        input int unsigned w);
        logic [31:0] diff;
        diff = a - b;
        return diff[w-1];
    endfunction

endpackage

// File: rtl/lsq_free_pick.sv
module lsq_free_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  busy,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/lsq_oldest_pick.sv
module lsq_oldest_pick #(
    parameter int N     = 8,
    parameter int IW    = 3,
    parameter int AGE_W = 7
) (
    input  logic [N-1:0]            mask,
    input  logic [N-1:0][AGE_W-1:0] ages,
    output logic                    found,
    output logic [IW-1:0]           idx
);
    import lsq_order_pkg::*;

    logic [AGE_W-1:0] best_age;

    always_comb begin
        found    = 1'b0;
        idx      = '0;
        best_age = '0;
        for (int i = 0; i < N; i++) begin
            if (mask[i] && (!found ||
                age_before(32'(ages[i]), 32'(best_age), AGE_W))) begin
                found    = 1'b1;
                idx      = IW'(i);
                best_age = ages[i];
            end
        end
    end
endmodule

// File: rtl/lsq_order_top.sv
module lsq_order_top #(
    parameter int LQ_DEPTH = 8,
    parameter int SQ_DEPTH = 8,
    parameter int AGE_W    = 7,
    localparam int LQ_IW   = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1,
    localparam int SQ_IW   = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             noalias_en,
    input  logic             alloc_vld,
    input  logic             alloc_may_ld,
    input  logic             alloc_may_st,
    input  logic             alloc_side_fx,
    input  logic [AGE_W-1:0] alloc_age,
    output logic [LQ_IW-1:0] alloc_lq_idx,
    output logic [SQ_IW-1:0] alloc_sq_idx,
    output logic             lq_full,
    output logic             sq_full,
    output logic             ld_gnt_vld,
    output logic [LQ_IW-1:0] ld_gnt_idx,
    output logic             st_gnt_vld,
    output logic [SQ_IW-1:0] st_gnt_idx,
    input  logic             ld_done_vld,
    input  logic [LQ_IW-1:0] ld_done_idx,
    input  logic             st_done_vld,
    input  logic [SQ_IW-1:0] st_done_idx
);
    import lsq_order_pkg::*;

    typedef struct packed {
        logic [LQ_DEPTH-1:0]            l_vld;
        logic [LQ_DEPTH-1:0]            l_gnt;
        logic [LQ_DEPTH-1:0]            l_bar;
        logic [LQ_DEPTH-1:0]            l_pair;
        logic [LQ_DEPTH-1:0][AGE_W-1:0] l_age;
        logic [SQ_DEPTH-1:0]            s_vld;
        logic [SQ_DEPTH-1:0]            s_gnt;
        logic [SQ_DEPTH-1:0]            s_bar;
        logic [SQ_DEPTH-1:0]            s_pair;
        logic [SQ_DEPTH-1:0][AGE_W-1:0] s_age;
    } state_t;

    state_t st_d, st_q;

    // Views of the state for the bound checker.
    logic [LQ_DEPTH-1:0] lq_vld_w, lq_gnt_w, lq_pair_w;
    logic [SQ_DEPTH-1:0] sq_vld_w, sq_gnt_w, sq_pair_w;
    assign lq_vld_w  = st_q.l_vld;
    assign lq_gnt_w  = st_q.l_gnt;
    assign lq_pair_w = st_q.l_pair;
    assign sq_vld_w  = st_q.s_vld;
    assign sq_gnt_w  = st_q.s_gnt;
    assign sq_pair_w = st_q.s_pair;

    // ---------------- free-slot selection ----------------
    logic             lfree_found, sfree_found;
    logic [LQ_IW-1:0] lfree_idx;
    logic [SQ_IW-1:0] sfree_idx;

    lsq_free_pick #(.N(LQ_DEPTH), .IW(LQ_IW)) i_lfree (
        .busy (st_q.l_vld),
        .found(lfree_found),
        .idx  (lfree_idx)
    );

    lsq_free_pick #(.N(SQ_DEPTH), .IW(SQ_IW)) i_sfree (
        .busy (st_q.s_vld),
        .found(sfree_found),
        .idx  (sfree_idx)
    );

    // ---------------- oldest-entry searches ----------------
    logic [LQ_DEPTH-1:0] l_wait;
    logic [SQ_DEPTH-1:0] s_wait;
    assign l_wait = st_q.l_vld & ~st_q.l_gnt;
    assign s_wait = st_q.s_vld & ~st_q.s_gnt;

    logic             lov_found, sov_found, lug_found;
    logic [LQ_IW-1:0] lov_idx, lug_idx;
    logic [SQ_IW-1:0] sov_idx;

    lsq_oldest_pick #(.N(LQ_DEPTH), .IW(LQ_IW), .AGE_W(AGE_W)) i_l_oldest (
        .mask (st_q.l_vld),
        .ages (st_q.l_age),
        .found(lov_found),
        .idx  (lov_idx)
    );

    lsq_oldest_pick #(.N(SQ_DEPTH), .IW(SQ_IW), .AGE_W(AGE_W)) i_s_oldest (
        .mask (st_q.s_vld),
        .ages (st_q.s_age),
        .found(sov_found),
        .idx  (sov_idx)
    );

    lsq_oldest_pick #(.N(LQ_DEPTH), .IW(LQ_IW), .AGE_W(AGE_W)) i_l_oldest_wait (
        .mask (l_wait),
        .ages (st_q.l_age),
        .found(lug_found),
        .idx  (lug_idx)
    );

    // Oldest surviving entries of each table and whether they form a full-barrier pair.
    logic [AGE_W-1:0] lov_age, sov_age, lug_age;
    logic             pair_at_head;
    always_comb begin
        lov_age = st_q.l_age[lov_idx];
        sov_age = st_q.s_age[sov_idx];
        lug_age = st_q.l_age[lug_idx];
        pair_at_head = lov_found && sov_found &&
                       st_q.l_pair[lov_idx] && st_q.s_pair[sov_idx] &&
                       !st_q.l_gnt[lov_idx] && !st_q.s_gnt[sov_idx] &&
                       (lov_age == sov_age);
    end

    // ---------------- eligibility ----------------
    logic [LQ_DEPTH-1:0] l_elig;
    logic [SQ_DEPTH-1:0] s_elig;

    always_comb begin
        for (int l = 0; l < LQ_DEPTH; l++) begin
            logic blk;
            blk = 1'b0;
            if (st_q.l_bar[l]) begin
                // barrier: must head the load table (and the store table when paired)
                if (l != int'(lov_idx)) blk = 1'b1;
                if (st_q.l_pair[l] && !pair_at_head) blk = 1'b1;
            end else begin
                for (int j = 0; j < LQ_DEPTH; j++) begin
                    if (j != l && l_wait[j] && st_q.l_bar[j] &&
                        age_before(32'(st_q.l_age[j]), 32'(st_q.l_age[l]), AGE_W))
                        blk = 1'b1;
                end
                for (int s = 0; s < SQ_DEPTH; s++) begin
                    if (s_wait[s] &&
                        age_before(32'(st_q.s_age[s]), 32'(st_q.l_age[l]), AGE_W)) begin
                        if (!noalias_en)
                            blk = 1'b1;
                        else if (lug_found &&
                                 age_before(32'(lug_age), 32'(st_q.s_age[s]), AGE_W))
                            blk = 1'b1;
                    end
                end
            end
            l_elig[l] = l_wait[l] && !blk;
        end

        for (int s = 0; s < SQ_DEPTH; s++) begin
            logic blk;
            blk = 1'b0;
            if (st_q.s_bar[s]) begin
                if (s != int'(sov_idx)) blk = 1'b1;
                if (st_q.s_pair[s] && !pair_at_head) blk = 1'b1;
            end else begin
                for (int j = 0; j < LQ_DEPTH; j++) begin
                    if (l_wait[j] &&
                        age_before(32'(st_q.l_age[j]), 32'(st_q.s_age[s]), AGE_W))
                        blk = 1'b1;
                end
                for (int k = 0; k < SQ_DEPTH; k++) begin
                    if (k != s && s_wait[k] &&
                        age_before(32'(st_q.s_age[k]), 32'(st_q.s_age[s]), AGE_W))
                        blk = 1'b1;
                end
            end
            s_elig[s] = s_wait[s] && !blk;
        end
    end

    lsq_oldest_pick #(.N(LQ_DEPTH), .IW(LQ_IW), .AGE_W(AGE_W)) i_l_grant (
        .mask (l_elig),
        .ages (st_q.l_age),
        .found(ld_gnt_vld),
        .idx  (ld_gnt_idx)
    );

    lsq_oldest_pick #(.N(SQ_DEPTH), .IW(SQ_IW), .AGE_W(AGE_W)) i_s_grant (
        .mask (s_elig),
        .ages (st_q.s_age),
        .found(st_gnt_vld),
        .idx  (st_gnt_idx)
    );

    // ---------------- next state ----------------
    op_kind_e kind;
    logic     need_l, need_s, accept;

    always_comb begin
        st_d   = st_q;
        kind   = classify(alloc_may_ld, alloc_may_st, alloc_side_fx);
        need_l = kind_uses_lq(kind);
        need_s = kind_uses_sq(kind);
        accept = alloc_vld && (need_l || need_s) &&
                 (!need_l || lfree_found) && (!need_s || sfree_found);

        if (ld_gnt_vld) st_d.l_gnt[ld_gnt_idx] = 1'b1;
        if (st_gnt_vld) st_d.s_gnt[st_gnt_idx] = 1'b1;

        if (ld_done_vld && (int'(ld_done_idx) < LQ_DEPTH)) begin
            if (st_q.l_vld[ld_done_idx] && st_q.l_gnt[ld_done_idx]) begin
                st_d.l_vld[ld_done_idx] = 1'b0;
                st_d.l_gnt[ld_done_idx] = 1'b0;
            end
        end
        if (st_done_vld && (int'(st_done_idx) < SQ_DEPTH)) begin
            if (st_q.s_vld[st_done_idx] && st_q.s_gnt[st_done_idx]) begin
                st_d.s_vld[st_done_idx] = 1'b0;
                st_d.s_gnt[st_done_idx] = 1'b0;
            end
        end

        if (accept && need_l) begin
            st_d.l_vld[lfree_idx]  = 1'b1;
            st_d.l_gnt[lfree_idx]  = 1'b0;
            st_d.l_bar[lfree_idx]  = kind_is_bar(kind);
            st_d.l_pair[lfree_idx] = (kind == OPK_FBAR);
            st_d.l_age[lfree_idx]  = alloc_age;
        end
        if (accept && need_s) begin
            st_d.s_vld[sfree_idx]  = 1'b1;
            st_d.s_gnt[sfree_idx]  = 1'b0;
            st_d.s_bar[sfree_idx]  = kind_is_bar(kind);
            st_d.s_pair[sfree_idx] = (kind == OPK_FBAR);
            st_d.s_age[sfree_idx]  = alloc_age;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alloc_lq_idx = lfree_idx;
    assign alloc_sq_idx = sfree_idx;
    assign lq_full      = !lfree_found;
    assign sq_full      = !sfree_found;

endmodule

// File: rtl/lsq_order_chk.sv
module lsq_order_chk #(
    parameter int LQ_N  = 8,
    parameter int SQ_N  = 8,
    parameter int LQ_IW = 3,
    parameter int SQ_IW = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_vld,
    input logic             alloc_may_ld,
    input logic             lq_full,
    input logic             ld_gnt_vld,
    input logic [LQ_IW-1:0] ld_gnt_idx,
    input logic             st_gnt_vld,
    input logic [SQ_IW-1:0] st_gnt_idx,
    input logic             ld_done_vld,
    input logic [LQ_IW-1:0] ld_done_idx,
    input logic [LQ_N-1:0]  lq_vld,
    input logic [LQ_N-1:0]  lq_gnt,
    input logic [LQ_N-1:0]  lq_pair,
    input logic [SQ_N-1:0]  sq_vld,
    input logic [SQ_N-1:0]  sq_gnt,
    input logic [SQ_N-1:0]  sq_pair
);
    AST_LD_GNT_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        ld_gnt_vld |-> (lq_vld[ld_gnt_idx] && !lq_gnt[ld_gnt_idx])); // R9

    AST_ST_GNT_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        st_gnt_vld |-> (sq_vld[st_gnt_idx] && !sq_gnt[st_gnt_idx])); // R9

    AST_LD_GNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_gnt_vld |=> (lq_vld[$past(ld_gnt_idx)] && lq_gnt[$past(ld_gnt_idx)])); // R9

    AST_FULL_BAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_gnt_vld && lq_pair[ld_gnt_idx]) |-> (st_gnt_vld && sq_pair[st_gnt_idx])); // R8

    AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_full && alloc_vld && alloc_may_ld && !ld_done_vld) |=> lq_full); // R3

    AST_DONE_EARLY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_done_vld && lq_vld[ld_done_idx] && !lq_gnt[ld_done_idx])
        |=> lq_vld[$past(ld_done_idx)]); // R10
endmodule

bind lsq_order_top lsq_order_chk #(
    .LQ_N (LQ_DEPTH),
    .SQ_N (SQ_DEPTH),
    .LQ_IW(LQ_IW),
    .SQ_IW(SQ_IW)
) i_lsq_order_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_vld   (alloc_vld),
    .alloc_may_ld(alloc_may_ld),
    .lq_full     (lq_full),
    .ld_gnt_vld  (ld_gnt_vld),
    .ld_gnt_idx  (ld_gnt_idx),
    .st_gnt_vld  (st_gnt_vld),
    .st_gnt_idx  (st_gnt_idx),
    .ld_done_vld (ld_done_vld),
    .ld_done_idx (ld_done_idx),
    .lq_vld      (lq_vld_w),
    .lq_gnt      (lq_gnt_w),
    .lq_pair     (lq_pair_w),
    .sq_vld      (sq_vld_w),
    .sq_gnt      (sq_gnt_w),
    .sq_pair     (sq_pair_w)
);

// File: tb/test_lsq_order_top.sv
module test_lsq_order_top;
    localparam int LQ_N = 4;
    localparam int SQ_N = 3;
    localparam int AW   = 5;
    localparam int LIW  = 2;
    localparam int SIW  = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           noalias_en = 1'b0;
    logic           alloc_vld = 1'b0, alloc_may_ld = 1'b0, alloc_may_st = 1'b0, alloc_side_fx = 1'b0;
    logic [AW-1:0]  alloc_age = '0;
    logic [LIW-1:0] alloc_lq_idx, ld_gnt_idx;
    logic [SIW-1:0] alloc_sq_idx, st_gnt_idx;
    logic           lq_full, sq_full, ld_gnt_vld, st_gnt_vld;
    logic           ld_done_vld = 1'b0, st_done_vld = 1'b0;
    logic [LIW-1:0] ld_done_idx = '0;
    logic [SIW-1:0] st_done_idx = '0;

    always #5 clk = ~clk;

    lsq_order_top #(.LQ_DEPTH(LQ_N), .SQ_DEPTH(SQ_N), .AGE_W(AW)) i_lsq_order_top (
        .clk(clk), .rst_n(rst_n), .noalias_en(noalias_en),
        .alloc_vld(alloc_vld), .alloc_may_ld(alloc_may_ld), .alloc_may_st(alloc_may_st),
        .alloc_side_fx(alloc_side_fx), .alloc_age(alloc_age),
        .alloc_lq_idx(alloc_lq_idx), .alloc_sq_idx(alloc_sq_idx),
        .lq_full(lq_full), .sq_full(sq_full),
        .ld_gnt_vld(ld_gnt_vld), .ld_gnt_idx(ld_gnt_idx),
        .st_gnt_vld(st_gnt_vld), .st_gnt_idx(st_gnt_idx),
        .ld_done_vld(ld_done_vld), .ld_done_idx(ld_done_idx),
        .st_done_vld(st_done_vld), .st_done_idx(st_done_idx)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // behavioural model: entries keyed by slot, ages are absolute sequence numbers
    bit mlv[LQ_N], mlg[LQ_N], mlb[LQ_N], mlp[LQ_N];
    int mla[LQ_N];
    bit msv[SQ_N], msg[SQ_N], msb[SQ_N], msp[SQ_N];
    int msa[SQ_N];
    int seq = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < LQ_N; i++) begin mlv[i] = 0; mlg[i] = 0; mlb[i] = 0; mlp[i] = 0; mla[i] = 0; end
        for (int i = 0; i < SQ_N; i++) begin msv[i] = 0; msg[i] = 0; msb[i] = 0; msp[i] = 0; msa[i] = 0; end
    endtask

    function automatic int low_free_l();
        for (int i = 0; i < LQ_N; i++) if (!mlv[i]) return i;
        return -1;
    endfunction
    function automatic int low_free_s();
        for (int i = 0; i < SQ_N; i++) if (!msv[i]) return i;
        return -1;
    endfunction

    // is store slot k the oldest valid store and is load slot l the oldest valid load
    function automatic bit l_head(input int l);
        for (int j = 0; j < LQ_N; j++) if (j != l && mlv[j] && mla[j] < mla[l]) return 0;
        return 1;
    endfunction
    function automatic bit s_head(input int s);
        for (int j = 0; j < SQ_N; j++) if (j != s && msv[j] && msa[j] < msa[s]) return 0;
        return 1;
    endfunction

    function automatic bit ld_ok(input int l);
        if (!mlv[l] || mlg[l]) return 0;
        if (mlb[l]) begin
            if (!l_head(l)) return 0;
            if (mlp[l]) begin
                for (int k = 0; k < SQ_N; k++)
                    if (msv[k] && msp[k] && !msg[k] && msa[k] == mla[l]) return s_head(k);
                return 0;
            end
            return 1;
        end
        for (int j = 0; j < LQ_N; j++)
            if (mlv[j] && !mlg[j] && mlb[j] && mla[j] < mla[l]) return 0;
        for (int s = 0; s < SQ_N; s++) begin
            if (msv[s] && !msg[s] && msa[s] < mla[l]) begin
                if (!noalias_en) return 0;
                for (int j = 0; j < LQ_N; j++)
                    if (mlv[j] && !mlg[j] && mla[j] < msa[s]) return 0;
            end
        end
        return 1;
    endfunction

    function automatic bit st_ok(input int s);
        if (!msv[s] || msg[s]) return 0;
        if (msb[s]) begin
            if (!s_head(s)) return 0;
            if (msp[s]) begin
                for (int k = 0; k < LQ_N; k++)
                    if (mlv[k] && mlp[k] && !mlg[k] && mla[k] == msa[s]) return l_head(k);
                return 0;
            end
            return 1;
        end
        for (int j = 0; j < LQ_N; j++) if (mlv[j] && !mlg[j] && mla[j] < msa[s]) return 0;
        for (int k = 0; k < SQ_N; k++) if (k != s && msv[k] && !msg[k] && msa[k] < msa[s]) return 0;
        return 1;
    endfunction

    function automatic int exp_ld();
        int b = -1;
        for (int l = 0; l < LQ_N; l++) if (ld_ok(l) && (b < 0 || mla[l] < mla[b])) b = l;
        return b;
    endfunction
    function automatic int exp_st();
        int b = -1;
        for (int s = 0; s < SQ_N; s++) if (st_ok(s) && (b < 0 || msa[s] < msa[b])) b = s;
        return b;
    endfunction

    function automatic int oldest_seq();
        int m = seq;
        for (int i = 0; i < LQ_N; i++) if (mlv[i] && mla[i] < m) m = mla[i];
        for (int i = 0; i < SQ_N; i++) if (msv[i] && msa[i] < m) m = msa[i];
        return m;
    endfunction

    // rule checks on the grant the design actually gives
    task automatic rule_checks();
        int gl, gs;
        gl = int'(ld_gnt_idx);
        gs = int'(st_gnt_idx);
        if (st_gnt_vld && gs < SQ_N && msv[gs] && !msb[gs]) begin
            bit ok = 1;
            for (int j = 0; j < LQ_N; j++) if (mlv[j] && !mlg[j] && mla[j] < msa[gs]) ok = 0;
            for (int k = 0; k < SQ_N; k++) if (msv[k] && !msg[k] && msa[k] < msa[gs]) ok = 0;
            chk(ok, "R4 store granted past older waiting entry", gs, -1);
        end
        if (ld_gnt_vld && mlv[gl] && !mlb[gl]) begin
            bit ok5 = 1, ok6 = 1, ok7 = 1;
            for (int s = 0; s < SQ_N; s++) begin
                if (msv[s] && !msg[s] && msa[s] < mla[gl]) begin
                    if (!noalias_en) ok5 = 0;
                    for (int j = 0; j < LQ_N; j++)
                        if (mlv[j] && !mlg[j] && mla[j] < msa[s]) ok6 = 0;
                end
            end
            for (int j = 0; j < LQ_N; j++) if (mlv[j] && !mlg[j] && mlb[j] && mla[j] < mla[gl]) ok7 = 0;
            if (!noalias_en) chk(ok5, "R5 load passed older store", gl, -1);
            chk(ok6, "R6 load passed older load across store", gl, -1);
            chk(ok7, "R7 load passed load barrier", gl, -1);
        end
        if (ld_gnt_vld && mlv[gl] && mlb[gl])
            chk(l_head(gl), "R7 load barrier granted while not oldest", gl, -1);
        if (st_gnt_vld && gs < SQ_N && msv[gs] && msb[gs])
            chk(s_head(gs), "R7 store barrier granted while not oldest", gs, -1);
        if (ld_gnt_vld && mlv[gl] && mlp[gl]) begin
            bit ok = st_gnt_vld && gs < SQ_N && msp[gs] && msa[gs] == mla[gl];
            chk(ok, "R8 full barrier halves granted together", int'(st_gnt_vld), 1);
        end
    endtask

    task automatic step(input int palloc, input int pdone);
        int el, es, fl, fs, r;
        bit nl, ns, acc;
        bit a_l, a_s, a_f;
        @(negedge clk);
        // stimulus
        alloc_vld = 0; alloc_may_ld = 0; alloc_may_st = 0; alloc_side_fx = 0;
        ld_done_vld = 0; st_done_vld = 0;
        if (int'($urandom % 100) < palloc && (seq - oldest_seq()) < 12) begin
            a_l = 0; a_s = 0; a_f = 0;
            r = int'($urandom % 8);
            case (r)
                1, 2: a_l = 1;
                3, 4: a_s = 1;
                5: begin a_l = 1; a_s = 1; end
                6: begin
                    a_f = 1;
                    case ($urandom % 3)
                        0: a_l = 1;
                        1: a_s = 1;
                        default: begin a_l = 1; a_s = 1; end
                    endcase
                end
                7: a_f = 1;
                default: ;
            endcase
            alloc_vld = 1; alloc_may_ld = a_l; alloc_may_st = a_s; alloc_side_fx = a_f;
        end
        alloc_age = seq[AW-1:0];
        if (int'($urandom % 100) < pdone) begin
            if ($urandom % 4 == 0) begin
                ld_done_vld = 1; ld_done_idx = LIW'($urandom % 4);
            end else begin
                int o = int'($urandom % LQ_N);
                for (int i = 0; i < LQ_N; i++) begin
                    int k = (o + i) % LQ_N;
                    if (!ld_done_vld && mlv[k] && mlg[k]) begin ld_done_vld = 1; ld_done_idx = LIW'(k); end
                end
            end
        end
        if (int'($urandom % 100) < pdone) begin
            if ($urandom % 4 == 0) begin
                st_done_vld = 1; st_done_idx = SIW'($urandom % 4);
            end else begin
                int o = int'($urandom % SQ_N);
                for (int i = 0; i < SQ_N; i++) begin
                    int k = (o + i) % SQ_N;
                    if (!st_done_vld && msv[k] && msg[k]) begin st_done_vld = 1; st_done_idx = SIW'(k); end
                end
            end
        end
        #1;
        // compare outputs against the model
        fl = low_free_l();
        fs = low_free_s();
        chk(lq_full == (fl < 0), "R3 lq_full", int'(lq_full), int'(fl < 0));
        chk(sq_full == (fs < 0), "R3 sq_full", int'(sq_full), int'(fs < 0));
        if (fl >= 0) chk(int'(alloc_lq_idx) == fl, "R2 R10 R11 lowest free load slot", int'(alloc_lq_idx), fl);
        if (fs >= 0) chk(int'(alloc_sq_idx) == fs, "R2 R10 R11 lowest free store slot", int'(alloc_sq_idx), fs);
        el = exp_ld();
        es = exp_st();
        chk(ld_gnt_vld == (el >= 0), "R9 load grant valid", int'(ld_gnt_vld), int'(el >= 0));
        if (el >= 0 && ld_gnt_vld) chk(int'(ld_gnt_idx) == el, "R9 load grant slot", int'(ld_gnt_idx), el);
        chk(st_gnt_vld == (es >= 0), "R9 store grant valid", int'(st_gnt_vld), int'(es >= 0));
        if (es >= 0 && st_gnt_vld) chk(int'(st_gnt_idx) == es, "R9 store grant slot", int'(st_gnt_idx), es);
        rule_checks();
        // model update for the coming edge
        @(posedge clk);
        if (ld_done_vld && mlv[ld_done_idx] && mlg[ld_done_idx]) begin
            mlv[ld_done_idx] = 0; mlg[ld_done_idx] = 0;
        end
        if (st_done_vld && int'(st_done_idx) < SQ_N && msv[st_done_idx] && msg[st_done_idx]) begin
            msv[st_done_idx] = 0; msg[st_done_idx] = 0;
        end
        if (el >= 0) mlg[el] = 1;
        if (es >= 0) msg[es] = 1;
        nl = alloc_may_ld;
        ns = alloc_may_st;
        acc = alloc_vld && (nl || ns) && (!nl || fl >= 0) && (!ns || fs >= 0);
        if (acc) begin
            if (nl) begin
                mlv[fl] = 1; mlg[fl] = 0; mlb[fl] = alloc_side_fx;
                mlp[fl] = alloc_side_fx && ns; mla[fl] = seq;
            end
            if (ns) begin
                msv[fs] = 1; msg[fs] = 0; msb[fs] = alloc_side_fx;
                msp[fs] = alloc_side_fx && nl; msa[fs] = seq;
            end
            seq++;
        end
    endtask

    task automatic do_reset();
        alloc_vld = 0; ld_done_vld = 0; st_done_vld = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        model_clear();
        @(negedge clk);
        rst_n = 1;
        #1;
        chk(!ld_gnt_vld && !st_gnt_vld, "R1 no grant after reset", int'(ld_gnt_vld | st_gnt_vld), 0);
        chk(!lq_full && !sq_full, "R1 not full after reset", int'(lq_full | sq_full), 0);
        chk(alloc_lq_idx == 0 && alloc_sq_idx == 0, "R1 slot zero after reset",
            int'(alloc_lq_idx) + int'(alloc_sq_idx), 0);
    endtask

    initial begin
        noalias_en = 0;
        do_reset();
        for (int i = 0; i < 400; i++) step(90, 10);     // tables fill, drops while full
        for (int i = 0; i < 3000; i++) step(60, 55);
        noalias_en = 1;
        do_reset();
        for (int i = 0; i < 400; i++) step(90, 10);
        for (int i = 0; i < 3000; i++) step(60, 55);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule